// File: doc/BRIEF.md
# Peripheral Control Line Unit

This unit manages two pairs of handshake and strobe lines, one pair per data port, and sits on a small register bus. The first line of each pair is an input only. It raises an interrupt flag on the edge that software selects. The second line of each pair runs in one of eight modes held in a line control register. Four modes are inputs: falling or rising edge, each with or without an independent flag. Four modes are outputs: handshake, one-clock pulse, fixed low and fixed high.

The flags clear when software touches the data address of their own port. A second address for port A reaches the same data but leaves the control lines alone. Handshake and pulse outputs start on a port-A read and on a port-B write. Every incoming line passes through a two-stage synchronizer before edge detection. The flag set by an input change therefore becomes visible on the third rising clock edge after the change. The unit does not hold the port data itself; a neighbouring block supplies it.

Top module: `ctl_lines`

## Requirements
- R1: After reset the line control register reads 0x00 and all four flags are clear. Both second lines are inputs (`a2_oe`, `b2_oe` low), and `a2_out` and `b2_out` are high.
- R2: Line control bit 0 selects the active edge of `a1_in` (0 falling, 1 rising), and bit 4 does the same for `b1_in`. The selected edge sets the line's flag on the third rising clock edge after the input changes; the other edge sets nothing.
- R3: Bits 3:1 hold the port-A second-line mode and bits 7:5 the port-B one. 000 is falling input, 001 falling input with independent flag, 010 rising input, 011 rising input with independent flag, 100 handshake, 101 pulse, 110 fixed low, 111 fixed high. In input modes the output enable is low. In output modes, edges on the second line set no flag.
- R4: A read or write of the port's own data address clears that port's flags: port B is address 0x0 and port A is 0x1. An access to the other port leaves them set. An edge that arrives in the same cycle as the clear wins.
- R5: Address 0xF is the port-A data address that bypasses the control lines. Accessing it neither clears a flag nor starts a handshake or pulse.
- R6: In the independent modes (001, 011) a port access leaves the second-line flag set. Writing a 1 to a flag bit at address 0xD clears that flag. The flag bits at 0xD are bit 0 A-second, bit 1 A-first, bit 3 B-second and bit 4 B-first, with all other bits 0. `line_flags` carries {B-first, B-second, A-first, A-second}.
- R7: In handshake mode the second line goes low on the clock edge of the starting access, a read for port A and a write for port B. It returns high on the same clock edge on which the active edge of that port's first line sets its flag.
- R8: In pulse mode the second line is low for exactly one clock after the starting access.
- R9: Fixed-low and fixed-high modes drive the second line to 0 and to 1 with the output enable high.
- R10: A write to address 0xC loads the line control register, and a read of 0xC returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Bus access strobe for this cycle |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data (line control or flags, else 0) |
| a1_in | input | 1 | Port A first line |
| a2_in | input | 1 | Port A second line, input side |
| b1_in | input | 1 | Port B first line |
| b2_in | input | 1 | Port B second line, input side |
| a2_out | output | 1 | Port A second line, output value |
| a2_oe | output | 1 | Port A second line output enable |
| b2_out | output | 1 | Port B second line, output value |
| b2_oe | output | 1 | Port B second line output enable |
| line_flags | output | 4 | Flags {B-first, B-second, A-first, A-second} |

## Verification
The bench checks the handshake return two clocks after the line change, when it must still be low, and again one clock later. A design with a different synchronizer depth, or one that releases on the inactive edge, misses the exact cycle. It swaps the read and write start rule between the ports and uses the bypass address; a design with those rules crossed or the bypass ignored would drop a line or clear a flag that must stay set. It also checks that an independent flag survives port accesses and goes only on a written 1. A design that applied the ordinary clear rule would lose that flag.

// File: rtl/ctl_lines_pkg.sv
package ctl_lines_pkg;
    localparam int AW     = 4;
    localparam int DW     = 8;
    localparam int NPORTS = 2;

    localparam logic [AW-1:0] ADDR_PB      = 4'h0;
    localparam logic [AW-1:0] ADDR_PA      = 4'h1;
    localparam logic [AW-1:0] ADDR_LCR     = 4'hC;
    localparam logic [AW-1:0] ADDR_FLAGS   = 4'hD;
    localparam logic [AW-1:0] ADDR_PA_BYP  = 4'hF;

    typedef enum logic [2:0] {
        M_IN_FALL     = 3'b000,
        M_IN_FALL_IND = 3'b001,
        M_IN_RISE     = 3'b010,
        M_IN_RISE_IND = 3'b011,
        M_OUT_HS      = 3'b100,
        M_OUT_PULSE   = 3'b101,
        M_OUT_LOW     = 3'b110,
        M_OUT_HIGH    = 3'b111
    } l2_mode_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) st_q[i] <= '0;
            else        st_q[i] <= st_d[i];
        end
    end

    assign d_out = st_q[STAGES-1];
endmodule

// File: rtl/ctl_pair.sv
module ctl_pair
    import ctl_lines_pkg::*;
#(
    parameter bit START_ON_READ = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       l1_s,
    input  logic       l2_s,
    input  logic       l1_rise,
    input  logic [2:0] mode,
    input  logic       acc_main,
    input  logic       acc_rd,
    input  logic       clr_l1,
    input  logic       clr_l2,
    output logic       flag_l1,
    output logic       flag_l2,
    output logic       l2_out,
    output logic       l2_oe
);
    typedef struct packed {
        logic l1_prev;
        logic l2_prev;
        logic f1;
        logic f2;
        logic hs;
    } pair_t;

    pair_t st_d, st_q;
    logic  e1, e2, is_in, indep, start;

    always_comb begin
        start = acc_main && (START_ON_READ ? acc_rd : !acc_rd);
        is_in = !mode[2];
        indep = is_in && mode[0];
        e1    = l1_rise ? (l1_s && !st_q.l1_prev) : (!l1_s && st_q.l1_prev);
        e2    = is_in && (mode[1] ? (l2_s && !st_q.l2_prev) : (!l2_s && st_q.l2_prev));

        st_d         = st_q;
        st_d.l1_prev = l1_s;
        st_d.l2_prev = l2_s;
        st_d.f1      = e1 || (st_q.f1 && !acc_main && !clr_l1);
        st_d.f2      = e2 || (st_q.f2 && !(acc_main && !indep) && !clr_l2);
        case (mode)
            M_OUT_HS: begin
                if (start)   st_d.hs = 1'b0;
                else if (e1) st_d.hs = 1'b1;
            end
            M_OUT_PULSE: st_d.hs = !start;
            default:     st_d.hs = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{l1_prev: 1'b0, l2_prev: 1'b0, f1: 1'b0, f2: 1'b0, hs: 1'b1};
        else        st_q <= st_d;
    end

    assign flag_l1 = st_q.f1;
    assign flag_l2 = st_q.f2;
    assign l2_oe   = mode[2];
    assign l2_out  = (mode == M_OUT_LOW)  ? 1'b0 :
                     (mode == M_OUT_HIGH) ? 1'b1 : st_q.hs;

    // R2
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e1 |=> flag_l1);

    // R4
    access_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_main && !e1) |=> !flag_l1);

    // R6
    indep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (indep && flag_l2 && !clr_l2) |=> flag_l2);

    // R7
    hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_OUT_HS && !l2_out && !e1) |=> (!l2_out || mode != M_OUT_HS));

    // R8
    pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_OUT_PULSE && !start && !l2_out) |=> (l2_out || mode != M_OUT_PULSE));
endmodule

// File: rtl/ctl_lines.sv
module ctl_lines
    import ctl_lines_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] rd_data,
    input  logic          a1_in,
    input  logic          a2_in,
    input  logic          b1_in,
    input  logic          b2_in,
    output logic          a2_out,
    output logic          a2_oe,
    output logic          b2_out,
    output logic          b2_oe,
    output logic [3:0]    line_flags
);
    localparam int NLINES = 2 * NPORTS;

    typedef struct packed {
        logic [DW-1:0] lcr;
    } top_t;

    top_t st_d, st_q;

    logic [NLINES-1:0] raw_in, sync_in;
    logic [NPORTS-1:0] f1, f2, out2, oe2, acc_main;
    logic              flag_wr;

    assign raw_in  = {b2_in, b1_in, a2_in, a1_in};
    assign flag_wr = acc_en && acc_wr && (acc_addr == ADDR_FLAGS);
    assign acc_main[0] = acc_en && (acc_addr == ADDR_PA);
    assign acc_main[1] = acc_en && (acc_addr == ADDR_PB);

    line_sync #(.W(NLINES), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (raw_in),
        .d_out(sync_in)
    );

    always_comb begin
        st_d = st_q;
        if (acc_en && acc_wr && (acc_addr == ADDR_LCR)) st_d.lcr = acc_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        ctl_pair #(.START_ON_READ(p == 0)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .l1_s    (sync_in[2*p]),
            .l2_s    (sync_in[2*p+1]),
            .l1_rise (st_q.lcr[4*p]),
            .mode    (st_q.lcr[4*p+3 : 4*p+1]),
            .acc_main(acc_main[p]),
            .acc_rd  (!acc_wr),
            .clr_l1  (flag_wr && acc_wdata[3*p+1]),
            .clr_l2  (flag_wr && acc_wdata[3*p]),
            .flag_l1 (f1[p]),
            .flag_l2 (f2[p]),
            .l2_out  (out2[p]),
            .l2_oe   (oe2[p])
        );
    end

    always_comb begin
        rd_data = '0;
        if (acc_en && !acc_wr) begin
            case (acc_addr)
                ADDR_LCR:   rd_data = st_q.lcr;
                ADDR_FLAGS: rd_data = {3'b000, f1[1], f2[1], 1'b0, f1[0], f2[0]};
                default:    rd_data = '0;
            endcase
        end
    end

    assign a2_out     = out2[0];
    assign a2_oe      = oe2[0];
    assign b2_out     = out2[1];
    assign b2_oe      = oe2[1];
    assign line_flags = {f1[1], f2[1], f1[0], f2[0]};

    // R10
    lcr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_addr == ADDR_LCR) |=> (st_q.lcr == $past(acc_wdata)));

    // R5
    bypass_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr == ADDR_PA_BYP && line_flags[1]) |=> line_flags[1]);
endmodule

// File: tb/tb_ctl_lines.sv
module tb_ctl_lines;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, acc_wr = 1'b0;
    logic [3:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rd_data;
    logic       a1_in = 0, a2_in = 0, b1_in = 0, b2_in = 0;
    logic       a2_out, a2_oe, b2_out, b2_oe;
    logic [3:0] line_flags;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] last_rd = '0;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;
    item_t q[$];
    item_t it;
    event  chk_ev;

    always #10 clk = ~clk;

    ctl_lines dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .a1_in(a1_in), .a2_in(a2_in), .b1_in(b1_in), .b2_in(b2_in),
        .a2_out(a2_out), .a2_oe(a2_oe), .b2_out(b2_out), .b2_oe(b2_oe),
        .line_flags(line_flags)
    );

    // sel: 0 line_flags, 1 a2_out, 2 a2_oe, 3 b2_out, 4 b2_oe, 5 last read data
    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return {4'b0, line_flags};
            1: return {7'b0, a2_out};
            2: return {7'b0, a2_oe};
            3: return {7'b0, b2_out};
            4: return {7'b0, b2_oe};
            default: return last_rd;
        endcase
    endfunction

    always begin
        @(chk_ev);
        while (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (observe(it.sel) !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, observe(it.sel), it.exp);
            end
        end
    end

    task automatic expect_(string req, int sel, logic [7:0] e);
        q.push_back('{req, sel, e});
    endtask

    task automatic judge();
        -> chk_ev;
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
        @(posedge clk); @(negedge clk);
        acc_en = 0; acc_wr = 0;
    endtask

    task automatic rd(logic [3:0] a);
        acc_en = 1; acc_wr = 0; acc_addr = a;
        #2 last_rd = rd_data;
        @(posedge clk); @(negedge clk);
        acc_en = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        expect_("R1", 0, 0); expect_("R1", 2, 0); expect_("R1", 4, 0);
        expect_("R1", 1, 1); expect_("R1", 3, 1);
        rd(4'hC); expect_("R1", 5, 8'h00); judge();

        // R2 falling mode ignores rise, takes fall
        a1_in = 1; settle(); expect_("R2", 0, 4'b0000); judge();
        a1_in = 0; settle(); expect_("R2", 0, 4'b0010); judge();
        // R4 port B access leaves A flags, port A access clears
        rd(4'h0); expect_("R4", 0, 4'b0010); judge();
        rd(4'h1); expect_("R4", 0, 4'b0000); judge();

        // R10 load and read back, R2 rising mode
        wr(4'hC, 8'h01); rd(4'hC); expect_("R10", 5, 8'h01); judge();
        a1_in = 1; settle(); expect_("R2", 0, 4'b0010); judge();
        // R5 bypass address keeps flag
        rd(4'hF); expect_("R5", 0, 4'b0010); judge();
        wr(4'hF, 8'h55); expect_("R5", 0, 4'b0010); judge();
        wr(4'h1, 8'h00); expect_("R4", 0, 4'b0000); judge();

        // R3 second line rising input
        wr(4'hC, 8'h05);
        a2_in = 1; settle(); expect_("R3", 0, 4'b0001); expect_("R3", 2, 0); judge();
        wr(4'h1, 8'h00); expect_("R4", 0, 4'b0000); judge();

        // R6 independent rising input
        wr(4'hC, 8'h07);
        a2_in = 0; settle(); expect_("R3", 0, 4'b0000); judge();
        a2_in = 1; settle(); expect_("R6", 0, 4'b0001); judge();
        rd(4'h1); expect_("R6", 0, 4'b0001); judge();
        wr(4'h1, 8'h00); expect_("R6", 0, 4'b0001); judge();
        rd(4'hD); expect_("R6", 5, 8'h01); judge();
        wr(4'hD, 8'h01); expect_("R6", 0, 4'b0000); judge();

        // R7 port A handshake, starts on read
        wr(4'hC, 8'h09); expect_("R7", 2, 1); expect_("R7", 1, 1); judge();
        wr(4'h1, 8'h00); expect_("R7", 1, 1); judge();
        rd(4'h1); expect_("R7", 1, 0); judge();
        repeat (2) @(negedge clk); expect_("R7", 1, 0); judge();
        a1_in = 0; settle(); expect_("R7", 1, 0); judge();
        a1_in = 1; repeat (2) @(negedge clk); expect_("R7", 1, 0); judge();
        @(negedge clk); expect_("R7", 1, 1); expect_("R2", 0, 4'b0010); judge();

        // R8 port A pulse
        wr(4'hC, 8'h0B);
        rd(4'h1); expect_("R8", 1, 0); judge();
        @(negedge clk); expect_("R8", 1, 1); judge();
        rd(4'hF); expect_("R5", 1, 1); judge();

        // R9 fixed levels
        wr(4'hC, 8'h0D); expect_("R9", 1, 0); expect_("R9", 2, 1); judge();
        wr(4'hC, 8'h0F); expect_("R9", 1, 1); judge();
        // R3 output mode: second-line edges set nothing
        a2_in = 0; settle(); a2_in = 1; settle(); expect_("R3", 0, 4'b0000); judge();

        // R7 port B handshake, starts on write
        wr(4'hC, 8'h90); expect_("R7", 4, 1); expect_("R7", 3, 1); judge();
        rd(4'h0); expect_("R7", 3, 1); judge();
        wr(4'h0, 8'h00); expect_("R7", 3, 0); judge();
        b1_in = 1; settle(); expect_("R7", 3, 1); expect_("R2", 0, 4'b1000); judge();
        rd(4'h1); expect_("R4", 0, 4'b1000); judge();
        wr(4'h0, 8'h00); expect_("R4", 0, 4'b0000); judge();

        // R8 port B pulse
        wr(4'hC, 8'hB0);
        rd(4'h0); expect_("R8", 3, 1); judge();
        wr(4'h0, 8'h00); expect_("R8", 3, 0); judge();
        @(negedge clk); expect_("R8", 3, 1); judge();

        // R6 port B independent rising input
        wr(4'hC, 8'h60);
        b2_in = 1; settle(); expect_("R6", 0, 4'b0100); expect_("R3", 4, 0); judge();
        wr(4'h0, 8'h00); expect_("R6", 0, 4'b0100); judge();
        rd(4'hD); expect_("R6", 5, 8'h08); judge();
        wr(4'hD, 8'h08); expect_("R6", 0, 4'b0000); judge();
        b1_in = 0; settle(); expect_("R2", 0, 4'b1000); judge();
        rd(4'hD); expect_("R6", 5, 8'h10); judge();
        wr(4'hD, 8'h10); expect_("R6", 0, 4'b0000); judge();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule